// File: doc/BRIEF.md
# Dual-Channel High/Low Tick PWM Generator

The block drives two independent pulse-width outputs from a small memory-mapped register bank. Each channel takes one of four tick-enable inputs, thins it with a 7-bit prescaler, and uses the resulting ticks to time a high phase and then a low phase. The length of each phase is a 16-bit tick count held in that channel's own register. A shared control word holds, for each channel, the source select, the prescaler value, a tick gate and an output enable.

Software writes the two counts for a channel, then writes the control word with the enable bit set. The waveform starts at the beginning of its high phase. Counts written while the channel runs are latched only at the end of the current period. Clearing the enable bit silences the output on the next clock. The block has no polarity setting. A zero low count still leaves one low tick per period, so a constant-high output cannot be produced.

Top module: `hilo_pwm_pair`

## Requirements
- R1: After reset, both outputs are low and every register reads as zero.
- R2: The count registers sit at byte offsets 0x0 (channel A) and 0x4 (channel B). Bits 31:16 of each hold the high count and bits 15:0 the low count. The control word at 0x8 reads back only its defined bits: 1:0 output enables (A, B), 5:4 and 7:6 source selects (A, B), 14:8 and 22:16 prescalers (A, B), 15 and 23 tick gates (A, B). All other bits and all other offsets read zero.
- R3: With a free-running source and prescaler 0, an enabled channel drives its output high for the high count in clock cycles and low for the low count, repeating. The first high cycle is the one right after the enabling write.
- R4: A prescaler value N lets one tick through for every N+1 ticks of the selected source, which stretches both phases by N+1.
- R5: A high count of zero keeps the output low for the whole period.
- R6: A low count of zero gives exactly one low tick per period.
- R7: Writing the control word with a channel's enable bit clear forces that output low in the cycle after the write, even in the middle of a high phase.
- R8: While a channel's tick gate is clear, its output is low and its phase position is held. Setting the gate again resumes from the held position.
- R9: Counts written while a channel runs take effect only from the next period boundary.
- R10: Setting the enable bit again after a stop restarts the channel at the beginning of its high phase.
- R11: The two channels run independently, each with its own counts, source and prescaler.
- R12: A channel counts only the source picked by its 2-bit select. Select value k takes bit k of the source tick vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| src_tick | input | 4 | Tick enables of the four sources |
| pwm_out | output | 2 | Channel outputs, bit 0 = A, bit 1 = B |

## Verification
A control write takes effect at the clock edge that samples it. The output is valid right after that edge, and each sample the bench takes is indexed from that edge. The first tick arrives N+1 edges later for prescaler N. The output level at sample j is therefore high exactly when floor(j/(N+1)) modulo (high + max(low,1)) is below the high count. A stop or a gate change shows in the very first sample after its write. The bench logs both outputs a few nanoseconds after every rising edge and compares the log, index by index, with this closed form. Reads are combinational and are sampled one nanosecond after the address is set.

// File: rtl/hpwm_pkg.sv
package hpwm_pkg;
  parameter int DATA_W  = 32;
  parameter int ADDR_W  = 4;
  parameter int CNT_W   = 16;
  parameter int DIV_W   = 7;
  parameter int NSRC    = 4;
  parameter int SEL_W   = $clog2(NSRC);
  parameter int NCH     = 2;

  localparam int OFS_CTRL    = 8;
  localparam int SEL_LSB     = 4;
  localparam int DIV_LSB     = 8;
  localparam int GATE_LSB    = 15;
  localparam int FIELD_STEP  = 8;

  typedef enum logic {PH_HIGH = 1'b1, PH_LOW = 1'b0} phase_t;

  typedef struct packed {
    logic             en;
    logic             gate;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
  } chan_cfg_t;

  function automatic int cnt_ofs(input int ch);
    return 4 * ch;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      m[ch] = 1'b1;
      for (int b = 0; b < SEL_W; b++) m[SEL_LSB + SEL_W*ch + b] = 1'b1;
      for (int b = 0; b < DIV_W; b++) m[DIV_LSB + FIELD_STEP*ch + b] = 1'b1;
      m[GATE_LSB + FIELD_STEP*ch] = 1'b1;
    end
    return m;
  endfunction

  function automatic chan_cfg_t decode_cfg(input logic [DATA_W-1:0] ctrl,
                                           input logic [DATA_W-1:0] cnt,
                                           input int ch);
    chan_cfg_t c;
    c.en   = ctrl[ch];
    c.sel  = ctrl[SEL_LSB + SEL_W*ch +: SEL_W];
    c.div  = ctrl[DIV_LSB + FIELD_STEP*ch +: DIV_W];
    c.gate = ctrl[GATE_LSB + FIELD_STEP*ch];
    c.hi   = cnt[DATA_W-1 -: CNT_W];
    c.lo   = cnt[CNT_W-1:0];
    return c;
  endfunction

  function automatic logic [CNT_W-1:0] low_len(input logic [CNT_W-1:0] lo);
    return (lo == '0) ? CNT_W'(1) : lo;
  endfunction

  function automatic logic last_tick(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] len);
    return ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, len};
  endfunction

  function automatic logic presc_wrap(input logic [DIV_W-1:0] pc,
                                      input logic [DIV_W-1:0] div);
    return pc >= div;
  endfunction
endpackage

// File: rtl/hpwm_regs.sv
module hpwm_regs
  import hpwm_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output chan_cfg_t [NCH-1:0]         cfg
);
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] cnt_q [NCH];
  logic              ctrl_hit;

  assign ctrl_hit = wr && (addr == ADDR_W'(OFS_CTRL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (ctrl_hit) ctrl_q <= wdata & ctrl_mask();
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_cnt
    localparam logic [ADDR_W-1:0] MY_OFS = ADDR_W'(cnt_ofs(ch));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q[ch] <= '0;
      else if (wr && addr == MY_OFS)    cnt_q[ch] <= wdata;
    end
    assign cfg[ch] = decode_cfg(ctrl_q, cnt_q[ch], ch);
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_CTRL)) rdata = ctrl_q;
    for (int ch = 0; ch < NCH; ch++)
      if (addr == ADDR_W'(cnt_ofs(ch))) rdata = cnt_q[ch];
  end
endmodule

// File: rtl/hpwm_prescale.sv
module hpwm_prescale
  import hpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             gate,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  input  logic [NSRC-1:0]  src,
  output logic             tick
);
  logic [DIV_W-1:0] pc;
  logic             src_hit;

  assign src_hit = en && gate && src[sel];
  assign tick    = src_hit && presc_wrap(pc, div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc <= '0;
    else if (!en)     pc <= '0;
    else if (src_hit) pc <= presc_wrap(pc, div) ? '0 : pc + DIV_W'(1);
  end

  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/hpwm_wave.sv
module hpwm_wave
  import hpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             gate,
  input  logic             tick,
  input  logic [CNT_W-1:0] hi,
  input  logic [CNT_W-1:0] lo,
  output logic             out
);
  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hi_lat;
  logic [CNT_W-1:0] lo_lat;
  logic             period_end;

  assign period_end = tick && phase == PH_LOW && last_tick(cnt, low_len(lo_lat));
  assign out        = en && gate && phase == PH_HIGH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_LOW;
      cnt    <= '0;
      hi_lat <= '0;
      lo_lat <= '0;
    end else if (!en || period_end) begin
      hi_lat <= hi;
      lo_lat <= lo;
      cnt    <= '0;
      phase  <= (hi != '0) ? PH_HIGH : PH_LOW;
    end else if (tick) begin
      if (phase == PH_HIGH && last_tick(cnt, hi_lat)) begin
        phase <= PH_LOW;
        cnt   <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  p_hi_zero_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_lat == '0) |-> !out);

  p_hold_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> (!en || ($stable(cnt) && $stable(phase))));
endmodule

// File: rtl/hilo_pwm_pair.sv
module hilo_pwm_pair
  import hpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   src_tick,
  output logic [NCH-1:0]    pwm_out
);
  chan_cfg_t [NCH-1:0] cfg;
  logic      [NCH-1:0] ch_tick;

  hpwm_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .cfg   (cfg)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    hpwm_prescale u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cfg[ch].en),
      .gate  (cfg[ch].gate),
      .sel   (cfg[ch].sel),
      .div   (cfg[ch].div),
      .src   (src_tick),
      .tick  (ch_tick[ch])
    );

    hpwm_wave u_wave (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cfg[ch].en),
      .gate  (cfg[ch].gate),
      .tick  (ch_tick[ch]),
      .hi    (cfg[ch].hi),
      .lo    (cfg[ch].lo),
      .out   (pwm_out[ch])
    );

    p_stop_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_CTRL) && !bus_wdata[ch]) |=> !pwm_out[ch]);
  end
endmodule

// File: tb/hilo_pwm_pair_test.sv
module hilo_pwm_pair_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick = 4'b0001;
  logic [1:0]  pwm_out;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int mark = 0;
  logic [1:0] log_mem [0:8191];

  always #5 clk = ~clk;

  hilo_pwm_pair uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick),
    .pwm_out(pwm_out)
  );

  always begin
    @(posedge clk);
    #3;
    log_mem[cyc % 8192] = pwm_out;
    cyc++;
  end

  function automatic logic [31:0] mk_ctrl(input bit ea, input bit ga, input int sa, input int da,
                                          input bit eb, input bit gb, input int sb, input int db);
    logic [31:0] v;
    v = '0;
    v[0] = ea; v[1] = eb;
    v[5:4] = 2'(sa); v[7:6] = 2'(sb);
    v[14:8] = 7'(da); v[22:16] = 7'(db);
    v[15] = ga; v[23] = gb;
    return v;
  endfunction

  function automatic logic [31:0] mk_cnt(input int hi, input int lo);
    return {16'(hi), 16'(lo)};
  endfunction

  function automatic bit exp_level(input int j, input int hi, input int lo, input int dv);
    int t, p;
    t = j / (dv + 1);
    p = hi + ((lo == 0) ? 1 : lo);
    return (t % p) < hi;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #4;
    bus_wr = 1'b0;
    mark = cyc - 1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_samples(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  function automatic bit sample(input int idx, input int ch);
    return log_mem[idx % 8192][ch];
  endfunction

  task automatic check_wave(input int ch, input int m, input int hi, input int lo,
                            input int dv, input int n, input string req);
    int bad;
    bad = 0;
    for (int j = 0; j < n; j++)
      if (sample(m + j, ch) != exp_level(j, hi, lo, dv)) begin
        if (bad == 0)
          check(1'b0, req, sample(m + j, ch), exp_level(j, hi, lo, dv));
        bad++;
      end
    if (bad == 0) check(1'b1, req, 0, 0);
  endtask

  task automatic stop_all();
    wr(4'h8, 32'h0);
    wait_samples(1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(pwm_out == 2'b00, "R1 outputs", pwm_out, 0);
    rd(4'h0, d); check(d == 0, "R1 cntA", d, 0);
    rd(4'h4, d); check(d == 0, "R1 cntB", d, 0);
    rd(4'h8, d); check(d == 0, "R1 ctrl", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(4'h0, 32'h1234_5678);
    wr(4'h4, 32'h9ABC_DEF0);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h0, d); check(d == 32'h1234_5678, "R2 cntA readback", d, 32'h1234_5678);
    rd(4'h4, d); check(d == 32'h9ABC_DEF0, "R2 cntB readback", d, 32'h9ABC_DEF0);
    rd(4'h8, d); check(d == 32'h00FF_FFF3, "R2 ctrl defined bits", d, 32'h00FF_FFF3);
    rd(4'hC, d); check(d == 0, "R2 unmapped offset", d, 0);
    stop_all();
  endtask

  task automatic t_basic();
    wr(4'h0, mk_cnt(3, 5));
    wr(4'h8, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
    wait_samples(40);
    check_wave(0, mark, 3, 5, 0, 40, "R3 hi3 lo5 waveform");
    check_wave(1, mark, 0, 1, 0, 40, "R11 idle channel B stays low");
    stop_all();
  endtask

  task automatic t_presc();
    wr(4'h0, mk_cnt(2, 3));
    wr(4'h8, mk_ctrl(1, 1, 0, 2, 0, 0, 0, 0));
    wait_samples(60);
    check_wave(0, mark, 2, 3, 2, 60, "R4 prescaler 2");
    stop_all();
  endtask

  task automatic t_hizero();
    wr(4'h0, mk_cnt(0, 4));
    wr(4'h8, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
    wait_samples(30);
    check_wave(0, mark, 0, 4, 0, 30, "R5 high count zero");
    stop_all();
  endtask

  task automatic t_lozero();
    wr(4'h0, mk_cnt(4, 0));
    wr(4'h8, mk_ctrl(1, 1, 0, 1, 0, 0, 0, 0));
    wait_samples(40);
    check_wave(0, mark, 4, 0, 1, 40, "R6 low count zero one low tick");
    stop_all();
  endtask

  task automatic t_stop_restart();
    int m0;
    wr(4'h0, mk_cnt(10, 2));
    wr(4'h8, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
    wait_samples(2);
    wr(4'h8, 32'h0);
    check(sample(mark - 1, 0) == 1'b1, "R7 high before stop", sample(mark - 1, 0), 1);
    check(sample(mark, 0) == 1'b0, "R7 low right after stop", sample(mark, 0), 0);
    wr(4'h0, mk_cnt(3, 5));
    wr(4'h8, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
    wait_samples(5);
    wr(4'h8, 32'h0);
    wr(4'h8, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
    m0 = mark;
    wait_samples(24);
    check_wave(0, m0, 3, 5, 0, 24, "R10 restart at high phase");
    stop_all();
  endtask

  task automatic t_gate();
    int m1, m2;
    wr(4'h0, mk_cnt(6, 6));
    wr(4'h8, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
    check(sample(mark, 0) == 1'b1, "R8 high after enable", sample(mark, 0), 1);
    wr(4'h8, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 0));
    m1 = mark;
    wait_samples(10);
    for (int j = 0; j < 10; j++)
      check(sample(m1 + j, 0) == 1'b0, "R8 low while gated", sample(m1 + j, 0), 0);
    wr(4'h8, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
    m2 = mark;
    wait_samples(14);
    for (int j = 0; j < 5; j++)
      check(sample(m2 + j, 0) == 1'b1, "R8 resumes high remainder", sample(m2 + j, 0), 1);
    check(sample(m2 + 5, 0) == 1'b0, "R8 low after held remainder", sample(m2 + 5, 0), 0);
    check(sample(m2 + 11, 0) == 1'b1, "R8 next period after resume", sample(m2 + 11, 0), 1);
    stop_all();
  endtask

  task automatic t_update();
    int m0;
    bit e;
    wr(4'h0, mk_cnt(2, 2));
    wr(4'h8, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
    m0 = mark;
    wr(4'h0, mk_cnt(5, 1));
    wait_samples(20);
    for (int j = 0; j < 20; j++) begin
      e = (j < 4) ? (j < 2) : (((j - 4) % 6) < 5);
      check(sample(m0 + j, 0) == e, "R9 new counts at boundary", sample(m0 + j, 0), e);
    end
    stop_all();
  endtask

  task automatic t_dual();
    src_tick = 4'b1001;
    wr(4'h0, mk_cnt(3, 1));
    wr(4'h4, mk_cnt(2, 2));
    wr(4'h8, mk_ctrl(1, 1, 0, 0, 1, 1, 3, 1));
    wait_samples(40);
    check_wave(0, mark, 3, 1, 0, 40, "R11 channel A alongside B");
    check_wave(1, mark, 2, 2, 1, 40, "R11 channel B own settings");
    stop_all();
  endtask

  task automatic t_select();
    src_tick = 4'b0001;
    wr(4'h0, mk_cnt(2, 2));
    wr(4'h8, mk_ctrl(1, 1, 3, 0, 0, 0, 0, 0));
    wait_samples(20);
    check_wave(0, mark, 1, 0, 25, 20, "R12 unselected source gives no ticks");
    stop_all();
    src_tick = 4'b1000;
    wr(4'h8, mk_ctrl(1, 1, 3, 0, 0, 0, 0, 0));
    wait_samples(20);
    check_wave(0, mark, 2, 2, 0, 20, "R12 selected source 3");
    stop_all();
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    wait_samples(1);
    t_reset();
    t_regs();
    t_basic();
    t_presc();
    t_hizero();
    t_lozero();
    t_stop_restart();
    t_gate();
    t_update();
    t_dual();
    t_select();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule